// File: doc/BRIEF.md
# Halting Debug Entry Controller

This block governs how a single core is brought into halted debug state. Two authentication pins are decoded into invasive and non-invasive permission flags. An external halt request is honoured only when invasive debug is allowed. Once the request is taken, the controller waits for the core's entry barrier to report completion and for the core's count of outstanding normal-mode memory accesses to fall to zero. It then enters the halted state, asserts the acknowledge and the drain-done output, and records the reason for entry in a status word.

A debugger can write one status bit that forces the acknowledge high regardless of state. A restart pulse leaves the halted state and drops the drain-done output. The acknowledge drops with it unless the forcing bit is still set. All pins are plain level or pulse controls. No data stream passes through the block, so it has no valid/ready interface and no back-pressure.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: `invasive_ok` equals `dbg_inv_en`. `noninvasive_ok` is high when either `dbg_inv_en` or `dbg_noninv_en` is high. Both are combinational.
- R2: While `invasive_ok` is low, a `halt_req` has no effect: `halt_ack`, `drain_done`, status bit 0 and the entry field stay unchanged.
- R3: An accepted request sets status bit 0 (halted) and `halt_ack` at the same clock edge. This happens only after a barrier pulse has been seen in the current entry attempt and `pending_cnt` is zero.
- R4: On entering the halted state, the entry-reason field `status[5:2]` is loaded with 4'b0100. It keeps that value until reset or the next entry.
- R5: `halt_ack` is high in every cycle in which the core is halted.
- R6: A write (`stat_wr`) sets status bit 10 to `stat_wdata[10]`; every other written bit is ignored. While bit 10 is 1, `halt_ack` is high in any state.
- R7: `drain_done` rises together with the halted state and only when `pending_cnt` was zero at that edge.
- R8: If `halt_req` falls before the halted state is reached, the controller returns to running. The entry field is not changed, and a later barrier does not halt the core.
- R9: In the halted state, a `restart` pulse clears halted and `drain_done` at the next edge. `halt_ack` then follows status bit 10.
- R10: After reset, `status` is all zeros and `halt_ack` and `drain_done` are low.
- R11: A nonzero `pending_cnt` holds the controller in its draining wait, even after the barrier pulse.
- R12: A barrier pulse that arrives before the request is accepted does not count toward entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_inv_en | input | 1 | Authentication: invasive debug enable |
| dbg_noninv_en | input | 1 | Authentication: non-invasive debug enable |
| halt_req | input | 1 | External halt request, held until acknowledged |
| barrier_done | input | 1 | One-cycle pulse: entry barrier completed |
| pending_cnt | input | CNT_W | Outstanding normal-mode memory accesses |
| restart | input | 1 | One-cycle pulse: leave halted state |
| stat_wr | input | 1 | Debugger write strobe for the status word |
| stat_wdata | input | STAT_W | Debugger write data |
| halt_ack | output | 1 | Debug acknowledge |
| drain_done | output | 1 | Barrier done and all prior accesses drained |
| invasive_ok | output | 1 | Invasive debug permitted |
| noninvasive_ok | output | 1 | Non-invasive debug permitted |
| status | output | STAT_W | Status: [0] halted, [5:2] entry reason, [10] forced ack |

## Verification
The bench sweeps all four authentication codes, with and without a request. A decoder that mixed up the two enables would halt when only the non-invasive enable is set. It would also report a wrong permission flag. The bench feeds a barrier while accesses are still outstanding, and separately a barrier before the request. A design that treated the barrier as sufficient on its own, or kept a stale barrier, would halt early. The bench drops the request halfway through an entry attempt and then sends a barrier. This exposes a design that keeps draining or writes the entry field anyway. Restart is exercised with the forcing bit set and with it clear, and a write with every other bit set is used to catch writable read-only bits.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
  typedef enum logic [1:0] {
    HS_RUN   = 2'd0,
    HS_DRAIN = 2'd1,
    HS_HALT  = 2'd2
  } halt_state_t;

  localparam int HALT_BIT   = 0;
  localparam int ENTRY_LSB  = 2;
  localparam int ENTRY_W    = 4;
  localparam int FORCE_BIT  = 10;
  localparam logic [ENTRY_W-1:0] ENTRY_EXT_REQ = 4'b0100;
endpackage

// File: rtl/dbg_auth_decode.sv
module dbg_auth_decode (
  input  logic inv_en,
  input  logic noninv_en,
  output logic inv_ok,
  output logic noninv_ok
);
  always_comb begin
    inv_ok    = inv_en;
    noninv_ok = inv_en | noninv_en;
  end
endmodule

// File: rtl/dbg_drain_track.sv
module dbg_drain_track #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             draining,
  input  logic             barrier_done,
  input  logic [CNT_W-1:0] pending_cnt,
  output logic             drain_met
);
  logic barrier_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      barrier_seen <= 1'b0;
    else if (!draining)
      barrier_seen <= 1'b0;
    else if (barrier_done)
      barrier_seen <= 1'b1;
  end

  always_comb drain_met = draining && (barrier_seen || barrier_done) &&
                          (pending_cnt == '0);

  p_stale_barrier_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !draining |=> !barrier_seen);
endmodule

// File: rtl/dbg_halt_fsm.sv
module dbg_halt_fsm
  import dbg_halt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inv_ok,
  input  logic        halt_req,
  input  logic        drain_met,
  input  logic        restart,
  output halt_state_t state,
  output logic        enter_halt,
  output logic        done
);
  halt_state_t nxt;

  always_comb begin
    nxt        = state;
    enter_halt = 1'b0;
    case (state)
      HS_RUN:   if (halt_req && inv_ok) nxt = HS_DRAIN;
      HS_DRAIN: begin
        if (!halt_req)
          nxt = HS_RUN;
        else if (drain_met) begin
          nxt        = HS_HALT;
          enter_halt = 1'b1;
        end
      end
      HS_HALT:  if (restart) nxt = HS_RUN;
      default:  nxt = HS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= HS_RUN;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      if (enter_halt)
        done <= 1'b1;
      else if (state == HS_HALT && restart)
        done <= 1'b0;
    end
  end

  p_no_perm_no_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == HS_RUN && !inv_ok) |=> state == HS_RUN);
  p_abort_on_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == HS_DRAIN && !halt_req) |=> state == HS_RUN);
  p_restart_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == HS_HALT && restart) |=> (!done && state == HS_RUN));
  p_halt_via_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == HS_HALT && $past(state) != HS_HALT) |-> $past(state) == HS_DRAIN);
endmodule

// File: rtl/dbg_status_reg.sv
module dbg_status_reg
  import dbg_halt_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enter_halt,
  input  logic              halted,
  input  logic              wr,
  input  logic [STAT_W-1:0] wdata,
  output logic              force_ack,
  output logic [STAT_W-1:0] status
);
  localparam logic [STAT_W-1:0] WMASK = STAT_W'(1) << FORCE_BIT;

  logic [STAT_W-1:0]  sw_q;
  logic [ENTRY_W-1:0] entry_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q    <= '0;
      entry_q <= '0;
    end else begin
      if (wr) sw_q <= wdata & WMASK;
      if (enter_halt) entry_q <= ENTRY_EXT_REQ;
    end
  end

  always_comb begin
    status = sw_q;
    status[ENTRY_LSB +: ENTRY_W] = entry_q;
    status[HALT_BIT] = halted;
    force_ack = sw_q[FORCE_BIT];
  end

  p_entry_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    enter_halt |=> status[ENTRY_LSB +: ENTRY_W] == ENTRY_EXT_REQ);
  p_entry_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enter_halt |=> $stable(entry_q));
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_halt_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_inv_en,
  input  logic              dbg_noninv_en,
  input  logic              halt_req,
  input  logic              barrier_done,
  input  logic [CNT_W-1:0]  pending_cnt,
  input  logic              restart,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] stat_wdata,
  output logic              halt_ack,
  output logic              drain_done,
  output logic              invasive_ok,
  output logic              noninvasive_ok,
  output logic [STAT_W-1:0] status
);
  halt_state_t st;
  logic enter_halt, drain_met, force_ack, halted;

  dbg_auth_decode u_auth (
    .inv_en    (dbg_inv_en),
    .noninv_en (dbg_noninv_en),
    .inv_ok    (invasive_ok),
    .noninv_ok (noninvasive_ok)
  );

  dbg_drain_track #(.CNT_W(CNT_W)) u_drain (
    .clk          (clk),
    .rst_n        (rst_n),
    .draining     (st == HS_DRAIN),
    .barrier_done (barrier_done),
    .pending_cnt  (pending_cnt),
    .drain_met    (drain_met)
  );

  dbg_halt_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .inv_ok     (invasive_ok),
    .halt_req   (halt_req),
    .drain_met  (drain_met),
    .restart    (restart),
    .state      (st),
    .enter_halt (enter_halt),
    .done       (drain_done)
  );

  always_comb halted = (st == HS_HALT);

  dbg_status_reg #(.STAT_W(STAT_W)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .enter_halt (enter_halt),
    .halted     (halted),
    .wr         (stat_wr),
    .wdata      (stat_wdata),
    .force_ack  (force_ack),
    .status     (status)
  );

  always_comb halt_ack = halted | force_ack;

  p_ack_when_halted_r5: assert property (@(posedge clk) disable iff (!rst_n)
    status[HALT_BIT] |-> halt_ack);
  p_forced_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    status[FORCE_BIT] |-> halt_ack);
  p_done_needs_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drain_done) |-> $past(pending_cnt) == '0);
  p_busy_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_cnt != '0 && !halted) |=> !halted);
  p_done_with_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done == halted);
endmodule

// File: tb/dbg_halt_ctrl_test.sv
module dbg_halt_ctrl_test;
  localparam int CNT_W  = 4;
  localparam int STAT_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dbg_inv_en = 0, dbg_noninv_en = 0, halt_req = 0, barrier_done = 0;
  logic [CNT_W-1:0] pending_cnt = '0;
  logic restart = 0, stat_wr = 0;
  logic [STAT_W-1:0] stat_wdata = '0;
  logic halt_ack, drain_done, invasive_ok, noninvasive_ok;
  logic [STAT_W-1:0] status;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dbg_halt_ctrl #(.CNT_W(CNT_W), .STAT_W(STAT_W)) uut (
    .clk(clk), .rst_n(rst_n), .dbg_inv_en(dbg_inv_en), .dbg_noninv_en(dbg_noninv_en),
    .halt_req(halt_req), .barrier_done(barrier_done), .pending_cnt(pending_cnt),
    .restart(restart), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .halt_ack(halt_ack), .drain_done(drain_done), .invasive_ok(invasive_ok),
    .noninvasive_ok(noninvasive_ok), .status(status));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; halt_req = 0; barrier_done = 0; pending_cnt = '0;
    restart = 0; stat_wr = 0; stat_wdata = '0;
    step(2);
    rst_n = 1;
    step(1);
  endtask

  task automatic pulse_barrier();
    barrier_done = 1; step(1); barrier_done = 0;
  endtask

  task automatic write_stat(logic [31:0] v);
    stat_wr = 1; stat_wdata = v; step(1); stat_wr = 0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    chk("R10 status", status, 32'h0);
    chk("R10 ack", {31'b0, halt_ack}, 32'd0);
    chk("R10 done", {31'b0, drain_done}, 32'd0);

    // Sweep all authentication codes through a full entry attempt
    for (int code = 0; code < 4; code++) begin
      do_reset();
      dbg_inv_en = code[1]; dbg_noninv_en = code[0];
      #1;
      chk("R1 inv", {31'b0, invasive_ok}, {31'b0, code[1]});
      chk("R1 noninv", {31'b0, noninvasive_ok}, {31'b0, code[1] | code[0]});
      halt_req = 1; pending_cnt = 4'd2;
      step(1);
      pulse_barrier();
      step(2);
      chk("R11 busy", {31'b0, halt_ack}, 32'd0);
      pending_cnt = 4'd0;
      step(1);
      if (code[1]) begin
        chk("R3 halted", {31'b0, status[0]}, 32'd1);
        chk("R5 ack", {31'b0, halt_ack}, 32'd1);
        chk("R7 done", {31'b0, drain_done}, 32'd1);
        chk("R4 entry", {28'b0, status[5:2]}, 32'd4);
        halt_req = 0; restart = 1; step(1); restart = 0;
        chk("R9 halted", {31'b0, status[0]}, 32'd0);
        chk("R9 done", {31'b0, drain_done}, 32'd0);
        chk("R9 ack", {31'b0, halt_ack}, 32'd0);
        chk("R4 sticky", {28'b0, status[5:2]}, 32'd4);
      end else begin
        chk("R2 status", status, 32'h0);
        chk("R2 ack", {31'b0, halt_ack}, 32'd0);
        chk("R2 done", {31'b0, drain_done}, 32'd0);
      end
      halt_req = 0;
    end

    // Barrier arriving together with zero count in the same cycle
    do_reset(); dbg_inv_en = 1; dbg_noninv_en = 0;
    halt_req = 1; step(1);
    pulse_barrier();
    chk("R3 same-cycle", {31'b0, halt_ack}, 32'd1);
    halt_req = 0; restart = 1; step(1); restart = 0;

    // Stale barrier before the request must not count
    do_reset(); dbg_inv_en = 1;
    pulse_barrier();
    halt_req = 1; step(4);
    chk("R12 stale", {31'b0, halt_ack}, 32'd0);
    pulse_barrier();
    chk("R12 fresh", {31'b0, halt_ack}, 32'd1);
    halt_req = 0; restart = 1; step(1); restart = 0;

    // Abort: request dropped before acknowledge
    do_reset(); dbg_inv_en = 1; pending_cnt = 4'd3;
    halt_req = 1; step(2);
    halt_req = 0; step(1);
    pending_cnt = 0;
    pulse_barrier();
    step(1);
    chk("R8 ack", {31'b0, halt_ack}, 32'd0);
    chk("R8 status", status, 32'h0);

    // Forced acknowledge through status bit 10
    do_reset(); dbg_inv_en = 1;
    write_stat(32'hFFFF_FBFF);
    chk("R6 ro bits", status, 32'h0);
    write_stat(32'h0000_0400);
    chk("R6 bit", status, 32'h0000_0400);
    chk("R6 ack run", {31'b0, halt_ack}, 32'd1);
    halt_req = 1; step(1); pulse_barrier();
    chk("R6 halted", status, 32'h0000_0411);
    halt_req = 0; restart = 1; step(1); restart = 0;
    chk("R9 forced ack", {31'b0, halt_ack}, 32'd1);
    chk("R9 done forced", {31'b0, drain_done}, 32'd0);
    write_stat(32'h0);
    chk("R6 clear", {31'b0, halt_ack}, 32'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule